// File: doc/BRIEF.md
# LCD Pixel Word Unpacker

This block sits between a frame-buffer fetch engine and a palette/colour stage of a display pipeline. It takes 32-bit memory words over a valid/ready handshake and splits each word into a stream of pixels, also handed off with valid/ready. The pixel depth comes from a 3-bit mode input. Depths of 1, 2, 4 and 8 bits produce palette indices. The 16-bit and 24-bit depths produce direct colour with 8-bit red, green and blue.

Three controls set how pixels are placed in a word:
- The default order is little-endian: the least significant pixel comes out first.
- A big-endian pixel flag makes the most significant pixel come out first.
- A big-endian byte flag reverses the bytes of the word first and then uses little-endian order. This flag overrides the pixel flag.

A BGR flag swaps red and blue. For 16-bit data, a 2-bit mux input picks between a 5-5-5-1 layout and a 5-6-5 layout, and one mux value forces the swap.

The mode, ordering, swap and mux settings are captured when a word is accepted. Changing them while a word is being emitted has no effect until the next word.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: After reset `pix_valid` is 0 and `word_ready` is 1. `word_ready` is 1 exactly when no pixel is pending, or when the last pixel of the current word is being taken in the same cycle. A word accepted at a clock edge shows its first pixel with `pix_valid` = 1 right after that edge.
- R2: Mode codes are 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 = 16 bpp and 5 = 24-bit colour. The number of pixels per word is 32, 16, 8, 4, 2 and 1 respectively.
- R3: While `pix_valid` = 1 and `pix_ready` = 0, every pixel output holds its value.
- R4: With both ordering flags clear, pixel k of a word is taken from bits [k*bpp +: bpp].
- R5: With only `cfg_be_pix` set, pixel 0 is the most significant bpp-wide field, and later pixels step downward through the word.
- R6: With `cfg_be_byte` set, the word's four bytes are reversed (byte 3 becomes byte 0) and then little-endian order applies. `cfg_be_pix` is ignored in this case.
- R7: In modes 0 to 3, `pix_is_index` = 1 and `pix_index` is the field zero-extended to 8 bits, with R, G and B at 0. In direct modes, `pix_is_index` = 0 and `pix_index` = 0.
- R8: In 16-bit mode with `mux_sel` = 1, the layout is 5-5-5-1: red in bits 4:0, green in 9:5 and blue in 14:10, with bit 15 ignored. Each 5-bit value v widens to 8 bits as {v, v[4:2]}.
- R9: In 16-bit mode with `mux_sel` = 0 or 2, the layout is 5-6-5: red in bits 4:0, green in 10:5 and blue in 15:11. Green widens as {g, 2'b00} and 5-bit values widen as in R8. Red and blue are swapped when `cfg_bgr` = 1.
- R10: In 16-bit mode with `mux_sel` = 3, the layout is 5-6-5 and red and blue are always swapped, whatever the value of `cfg_bgr`.
- R11: In mode 5, red is byte 0, green is byte 1 and blue is byte 2 of the ordered word, and byte 3 is ignored. In every direct mode, `cfg_bgr` = 1 swaps red and blue, except that `mux_sel` = 3 forces the swap (R10).
- R12: The mode, ordering, BGR and mux settings are sampled when a word is accepted. Changes while that word's pixels are emitted do not alter them.
- R13: Mode codes 6 and 7 behave exactly like mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Pixel depth code |
| cfg_bgr | input | 1 | Swap red and blue |
| cfg_be_byte | input | 1 | Reverse bytes, then little-endian order |
| cfg_be_pix | input | 1 | Most significant pixel first |
| mux_sel | input | 2 | 16-bit layout select |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Word can be accepted |
| word_data | input | 32 | Frame-buffer word |
| pix_valid | output | 1 | Pixel present |
| pix_ready | input | 1 | Pixel taken by sink |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index |
| pix_r | output | 8 | Red |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |

## Verification
The bench chooses words whose fields differ between each of the three orderings. A design that gave the pixel flag priority over the byte flag, or that swapped orderings, therefore shows a wrong first pixel. One 16-bit word is sent with every mux value and with bit 15 set. This exposes a wrong field split, an intensity bit that leaks into blue, widening by zero-fill where bit copying is required, or a mux value 3 that follows the BGR flag. Under back-pressure, the settings are changed in the middle of a word. A design that decodes from live settings instead of captured ones then emits wrong later pixels or the wrong pixel count.

// File: rtl/lcd_unpk_pkg.sv
package lcd_unpk_pkg;

  typedef enum logic [2:0] {
    MODE_1BPP  = 3'd0,
    MODE_2BPP  = 3'd1,
    MODE_4BPP  = 3'd2,
    MODE_8BPP  = 3'd3,
    MODE_16BPP = 3'd4,
    MODE_24BPP = 3'd5,
    MODE_ALT6  = 3'd6,
    MODE_ALT7  = 3'd7
  } pix_mode_e;

  typedef struct packed {
    pix_mode_e  mode;
    logic       bgr;
    logic       be_byte;
    logic       be_pix;
    logic [1:0] mux;
  } unpk_cfg_t;

  typedef struct packed {
    logic       is_index;
    logic [7:0] index;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pixel_t;

  // log2 of the container width of one pixel
  function automatic logic [2:0] bpp_log2(input pix_mode_e m);
    case (m)
      MODE_1BPP:  return 3'd0;
      MODE_2BPP:  return 3'd1;
      MODE_4BPP:  return 3'd2;
      MODE_8BPP:  return 3'd3;
      MODE_24BPP: return 3'd5;
      default:    return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lcd_unpk_order.sv
module lcd_unpk_order
  import lcd_unpk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        lg_i,
  input  logic              be_byte_i,
  input  logic              be_pix_i,
  output logic [WORD_W-1:0] norm_o
);
  localparam int NBYTE = WORD_W / 8;
  localparam int NSIZE = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0]             bswap;
  logic [NSIZE-1:0][WORD_W-1:0]  prev;

  // byte lanes reversed
  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_byte
    assign bswap[gb*8 +: 8] = word_i[(NBYTE-1-gb)*8 +: 8];
  end

  // one pixel-order reversal per supported container width
  for (genvar gs = 0; gs < NSIZE; gs++) begin : g_size
    localparam int PW = 1 << gs;
    localparam int NP = WORD_W / PW;
    for (genvar gp = 0; gp < NP; gp++) begin : g_pix
      assign prev[gs][gp*PW +: PW] = word_i[(NP-1-gp)*PW +: PW];
    end
  end

  always_comb begin
    if (be_byte_i)     norm_o = bswap;
    else if (be_pix_i) norm_o = prev[lg_i];
    else               norm_o = word_i;
  end

endmodule

// File: rtl/lcd_unpk_decode.sv
module lcd_unpk_decode
  import lcd_unpk_pkg::*;
(
  input  logic [23:0] src_i,
  input  pix_mode_e   mode_i,
  input  logic        bgr_i,
  input  logic [1:0]  mux_i,
  output pixel_t      pix_o
);
  logic [15:0] hw;
  logic [7:0]  r8, g8, b8;
  logic        swap;

  always_comb begin
    pix_o = '0;
    hw    = src_i[15:0];
    r8    = '0;
    g8    = '0;
    b8    = '0;
    swap  = bgr_i;
    case (mode_i)
      MODE_1BPP: begin
        pix_o.is_index = 1'b1;
        pix_o.index    = {7'd0, src_i[0]};
      end
      MODE_2BPP: begin
        pix_o.is_index = 1'b1;
        pix_o.index    = {6'd0, src_i[1:0]};
      end
      MODE_4BPP: begin
        pix_o.is_index = 1'b1;
        pix_o.index    = {4'd0, src_i[3:0]};
      end
      MODE_8BPP: begin
        pix_o.is_index = 1'b1;
        pix_o.index    = src_i[7:0];
      end
      MODE_24BPP: begin
        r8 = src_i[7:0];
        g8 = src_i[15:8];
        b8 = src_i[23:16];
      end
      default: begin
        if (mux_i == 2'd1) begin
          r8 = {hw[4:0],   hw[4:2]};
          g8 = {hw[9:5],   hw[9:7]};
          b8 = {hw[14:10], hw[14:12]};
        end else begin
          r8 = {hw[4:0],   hw[4:2]};
          g8 = {hw[10:5],  2'b00};
          b8 = {hw[15:11], hw[15:13]};
        end
        if (mux_i == 2'd3) swap = 1'b1;
      end
    endcase
    if (!pix_o.is_index) begin
      pix_o.r = swap ? b8 : r8;
      pix_o.g = g8;
      pix_o.b = swap ? r8 : b8;
    end
  end

endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
  import lcd_unpk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_bgr,
  input  logic              cfg_be_byte,
  input  logic              cfg_be_pix,
  input  logic [1:0]        mux_sel,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_is_index,
  output logic [7:0]        pix_index,
  output logic [7:0]        pix_r,
  output logic [7:0]        pix_g,
  output logic [7:0]        pix_b
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  unpk_cfg_t          cfg_in, cfg_q, cfg_cur;
  logic [WORD_W-1:0]  norm, sh_q, src, sh_next;
  logic [CNT_W-1:0]   left_q, step, ppw_new;
  logic [2:0]         lg_in, lg_cur;
  pixel_t             dec, out_q;
  logic               vld_q, accept, take;

  assign cfg_in = '{mode: pix_mode_e'(cfg_mode), bgr: cfg_bgr,
                    be_byte: cfg_be_byte, be_pix: cfg_be_pix, mux: mux_sel};

  assign word_ready = !vld_q || (pix_ready && (left_q == '0));
  assign accept     = word_valid && word_ready;
  assign take       = vld_q && pix_ready;

  assign lg_in = bpp_log2(cfg_in.mode);

  lcd_unpk_order #(.WORD_W(WORD_W)) u_order (
    .word_i    (word_data),
    .lg_i      (lg_in),
    .be_byte_i (cfg_in.be_byte),
    .be_pix_i  (cfg_in.be_pix),
    .norm_o    (norm)
  );

  assign src     = accept ? norm : sh_q;
  assign cfg_cur = accept ? cfg_in : cfg_q;
  assign lg_cur  = bpp_log2(cfg_cur.mode);
  assign step    = CNT_W'(1) << lg_cur;
  assign sh_next = src >> step;
  assign ppw_new = (CNT_W'(WORD_W) >> lg_in) - CNT_W'(1);

  lcd_unpk_decode u_dec (
    .src_i  (src[23:0]),
    .mode_i (cfg_cur.mode),
    .bgr_i  (cfg_cur.bgr),
    .mux_i  (cfg_cur.mux),
    .pix_o  (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
      out_q  <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      out_q  <= dec;
      sh_q   <= sh_next;
      left_q <= ppw_new;
      cfg_q  <= cfg_in;
    end else if (take) begin
      if (left_q != '0) begin
        out_q  <= dec;
        sh_q   <= sh_next;
        left_q <= left_q - CNT_W'(1);
      end else begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign pix_valid    = vld_q;
  assign pix_is_index = out_q.is_index;
  assign pix_index    = out_q.index;
  assign pix_r        = out_q.r;
  assign pix_g        = out_q.g;
  assign pix_b        = out_q.b;

endmodule

// File: rtl/lcd_unpk_chk.sv
module lcd_unpk_chk (
  input logic       clk,
  input logic       rst,
  input logic       word_valid,
  input logic       word_ready,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic       pix_is_index,
  input logic [7:0] pix_index,
  input logic [7:0] pix_r,
  input logic [7:0] pix_g,
  input logic [7:0] pix_b
);
  // R1
  ack_to_pix_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_ready |=> pix_valid);

  // R1
  stall_blocks_word_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |-> !word_ready);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> word_ready);

  // R3
  hold_pix_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_is_index) &&
      $stable(pix_index) && $stable(pix_r) && $stable(pix_g) && $stable(pix_b));

  // R7
  idx_no_rgb_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && pix_is_index |-> {pix_r, pix_g, pix_b} == 24'd0);

  // R7
  direct_no_idx_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_is_index |-> pix_index == 8'd0);

endmodule

bind lcd_pixel_unpacker lcd_unpk_chk i_unpk_chk (
  .clk          (clk),
  .rst          (rst),
  .word_valid   (word_valid),
  .word_ready   (word_ready),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_is_index (pix_is_index),
  .pix_index    (pix_index),
  .pix_r        (pix_r),
  .pix_g        (pix_g),
  .pix_b        (pix_b)
);

// File: tb/test_lcd_pixel_unpacker.sv
module test_lcd_pixel_unpacker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mode = '0;
  logic        cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0;
  logic [1:0]  mux_sel = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic        pix_is_index;
  logic [7:0]  pix_index, pix_r, pix_g, pix_b;

  int n_checks = 0;
  int n_errors = 0;
  logic [32:0] got [0:63];
  int          got_n;

  always #2.5 clk = ~clk;

  lcd_pixel_unpacker i_lcd_pixel_unpacker (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .mux_sel(mux_sel),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_is_index(pix_is_index),
    .pix_index(pix_index), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        bgr;
    logic        beb;
    logic        bep;
    logic [1:0]  mux;
    logic [31:0] w;
    logic [32:0] exp;   // {is_index, index, r, g, b} of pixel 0
    logic [5:0]  cnt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h8000_0001, {1'b1, 8'h01, 24'h000000}, 6'd32}, // R4 R7 R2
    '{3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000_0001, {1'b1, 8'h00, 24'h000000}, 6'd32}, // R5
    '{3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0300_0000, {1'b1, 8'h03, 24'h000000}, 6'd16}, // R6 R2
    '{3'd2, 1'b0, 1'b0, 1'b1, 2'd0, 32'hA000_0005, {1'b1, 8'h0A, 24'h000000}, 6'd8},  // R5 R2
    '{3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h1122_33C4, {1'b1, 8'hC4, 24'h000000}, 6'd4},  // R4 R2
    '{3'd2, 1'b0, 1'b1, 1'b1, 2'd0, 32'h1234_5678, {1'b1, 8'h02, 24'h000000}, 6'd8},  // R6 priority
    '{3'd4, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_8C5F, {1'b0, 8'h00, 24'hFF1018}, 6'd2},  // R8
    '{3'd4, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0000_8C5F, {1'b0, 8'h00, 24'h8C88FF}, 6'd2},  // R9 R11
    '{3'd4, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0000_8C5F, {1'b0, 8'h00, 24'h8C88FF}, 6'd2},  // R10
    '{3'd4, 1'b0, 1'b0, 1'b1, 2'd0, 32'h8C5F_0000, {1'b0, 8'h00, 24'hFF888C}, 6'd2},  // R9 R5
    '{3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0033_2211, {1'b0, 8'h00, 24'h112233}, 6'd1},  // R11 R2
    '{3'd5, 1'b1, 1'b1, 1'b0, 2'd0, 32'h1122_3300, {1'b0, 8'h00, 24'h332211}, 6'd1},  // R11 R6
    '{3'd6, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_8C5F, {1'b0, 8'h00, 24'hFF1018}, 6'd2},  // R13
    '{3'd7, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0000_8C5F, {1'b0, 8'h00, 24'h8C88FF}, 6'd2}   // R13
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic bgr, input logic beb,
                         input logic bep, input logic [1:0] mx);
    cfg_mode = m; cfg_bgr = bgr; cfg_be_byte = beb; cfg_be_pix = bep; mux_sel = mx;
  endtask

  // offer a word at a falling edge, hold until accepted, return at next falling edge
  task automatic put_word(input logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // with pix_ready high, collect pixels until the stream stops
  task automatic drain();
    got_n = 0;
    while (pix_valid && got_n < 64) begin
      got[got_n] = {pix_is_index, pix_index, pix_r, pix_g, pix_b};
      got_n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pix_valid", 64'(pix_valid), 64'd0);
    chk("R1 reset word_ready", 64'(word_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      set_cfg(VT[i].mode, VT[i].bgr, VT[i].beb, VT[i].bep, VT[i].mux);
      put_word(VT[i].w);
      drain();
      chk($sformatf("table %0d first pixel", i), 64'(got[0]), 64'(VT[i].exp));
      chk($sformatf("R2 table %0d count", i), 64'(got_n), 64'(VT[i].cnt));
    end

    // R4: 4bpp little-endian walks nibbles upward
    set_cfg(3'd2, 1'b0, 1'b0, 1'b0, 2'd0);
    put_word(32'h8765_4321);
    drain();
    for (int k = 0; k < 8; k++)
      chk($sformatf("R4 nibble %0d", k), 64'(got[k][31:24]), 64'(k + 1));

    // R6: 8bpp byte-reversed gives memory byte order
    set_cfg(3'd3, 1'b0, 1'b1, 1'b0, 2'd0);
    put_word(32'h1122_3344);
    drain();
    for (int k = 0; k < 4; k++)
      chk($sformatf("R6 byte %0d", k), 64'(got[k][31:24]), 64'(8'h11 * (k + 1)));

    // R5: 2bpp big-endian pixel steps down from the top
    set_cfg(3'd1, 1'b0, 1'b0, 1'b1, 2'd0);
    put_word(32'h1B00_0000);
    drain();
    for (int k = 0; k < 4; k++)
      chk($sformatf("R5 pair %0d", k), 64'(got[k][31:24]), 64'(k));

    // R3 / R1: back-pressure holds the pixel and blocks new words
    pix_ready = 1'b0;
    set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 2'd0);
    put_word(32'h4433_2211);
    chk("R3 first under stall", 64'(pix_index), 64'h11);
    // R12: settings changed mid-word must not take effect
    set_cfg(3'd0, 1'b1, 1'b0, 1'b1, 2'd3);
    repeat (3) @(negedge clk);
    chk("R3 held index", 64'(pix_index), 64'h11);
    chk("R3 held valid", 64'(pix_valid), 64'd1);
    chk("R1 not ready while stalled", 64'(word_ready), 64'd0);
    pix_ready = 1'b1;
    drain();
    chk("R12 count after cfg change", 64'(got_n), 64'd4);
    chk("R12 second pixel", 64'(got[1][31:24]), 64'h22);
    chk("R12 last pixel", 64'(got[3][31:24]), 64'h44);

    // R1: ready rises in the cycle the last pixel is taken
    pix_ready = 1'b0;
    set_cfg(3'd5, 1'b0, 1'b0, 1'b0, 2'd0);
    put_word(32'h00AA_BBCC);
    chk("R1 single pixel stall ready", 64'(word_ready), 64'd0);
    pix_ready = 1'b1;
    #1;
    chk("R1 ready on last take", 64'(word_ready), 64'd1);
    @(negedge clk);
    chk("R1 idle after last", 64'(pix_valid), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule